// File: doc/BRIEF.md
# Decimating Eight-Channel Sample Multiplexer

This block accepts eight parallel 10-bit sample streams arriving at 40 MHz. It reduces each stream by four to a 10 MHz rate and interleaves the reduced streams into one word stream at 80 MHz. A single shared downstream filter can therefore serve all channels, one channel per processing slot. Each output word carries its channel index and a marker that opens each frame.

The block runs entirely on the 80 MHz clock. The 40 MHz sample rate is modelled as every second fast cycle, counted from the release of reset, so no asynchronous crossing is needed. Each channel sums four consecutive samples into a 12-bit result with no precision lost. Completed sums are parked in a hold bank, and a rotating selector sends them out in fixed channel order, filling all eight slots of every frame.

Top module: `dmx_octal_mux`

## Requirements
- R1: Input samples are taken only on the edges whose index since reset release is even (edge 0, 2, 4, ...). Values present at odd-indexed edges have no effect on any output.
- R2: Each output word is the exact sum of four consecutive taken samples of one channel, 12 bits wide with no truncation. All-maximum inputs (1023) give 4092.
- R3: While valid, consecutive output cycles carry channel indices 0,1,...,7 and then wrap to 0. Each frame has exactly eight slots.
- R4: The frame-start flag is high exactly in the valid slot whose channel index is 0.
- R5: After reset, valid is low until the first decimation window completes. The first valid word appears after edge 7, carries channel 0, and valid then stays high every cycle.
- R6: The sum for window w of channel c (samples taken at edges 8w, 8w+2, 8w+4, 8w+6) is presented after edge 8w+7+c.
- R7: A synchronous active-high reset drives data, channel, frame-start and valid to zero and restarts the sample phase. It also acts when asserted in the middle of a window.
- R8: Windows are independent: no part of one window's sum carries into the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 80 MHz processing clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_in | input | 80 | Eight 10-bit samples, channel c at bits [10c+9:10c] |
| out_data | output | 12 | Decimated sum for the current slot |
| out_chan | output | 3 | Channel index of the current slot |
| out_first | output | 1 | High in the channel-0 slot of each frame |
| out_valid | output | 1 | Slot carries a completed window |

## Verification
The bench builds the block with its default values: eight channels, 10-bit samples and decimation by four. This is the only shape in which the eight slots of a frame exactly match one decimated period. With these values every slot of every frame in a run is compared against sums the bench computes, across several sample patterns: arithmetic ramps, all-zero, all-maximum (4092) and a single hot channel. Conflicting junk is driven on every odd cycle to show those values are ignored. Repeated resets, including one in the middle of a window, expose phase restart and the startup latency.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int unsigned DMX_NCH_DEF  = 8;
    localparam int unsigned DMX_WIN_DEF  = 10;
    localparam int unsigned DMX_DEC_DEF  = 4;
endpackage

// File: rtl/dmx_phase.sv
module dmx_phase #(
    parameter int unsigned NCH = 8,
    parameter int unsigned DEC = 4,
    localparam int unsigned CH_W  = $clog2(NCH),
    localparam int unsigned SUB_W = (DEC > 1) ? $clog2(DEC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [CH_W-1:0] cnt,
    output logic            cap_en,
    output logic            win_first,
    output logic            win_last
);
    typedef struct packed {
        logic [CH_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [SUB_W-1:0] sub;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == CH_W'(NCH - 1)) ? '0 : st_q.cnt + 1'b1;
        sub       = SUB_W'(st_q.cnt >> 1);
        cap_en    = ~st_q.cnt[0];
        win_first = cap_en && (sub == '0);
        win_last  = cap_en && (sub == SUB_W'(DEC - 1));
        cnt       = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dmx_accum.sv
module dmx_accum #(
    parameter int unsigned W_IN  = 10,
    parameter int unsigned W_OUT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             win_first,
    input  logic             win_last,
    input  logic [W_IN-1:0]  smp,
    output logic [W_OUT-1:0] hold
);
    typedef struct packed {
        logic [W_OUT-1:0] acc;
        logic [W_OUT-1:0] hold;
    } st_t;

    st_t st_d, st_q;
    logic [W_OUT-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = (win_first ? '0 : st_q.acc) + W_OUT'(smp);
        if (cap_en) begin
            st_d.acc = sum;
            if (win_last) st_d.hold = sum;
        end
        hold = st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dmx_slot_mux.sv
module dmx_slot_mux #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned W_OUT = 12,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CH_W-1:0]      cnt,
    input  logic                 win_last,
    input  logic [NCH*W_OUT-1:0] bank,
    output logic [W_OUT-1:0]     out_data,
    output logic [CH_W-1:0]      out_chan,
    output logic                 out_first,
    output logic                 out_valid
);
    typedef struct packed {
        logic             ready;
        logic [W_OUT-1:0] data;
        logic [CH_W-1:0]  chan;
        logic             first;
        logic             valid;
    } st_t;

    st_t st_d, st_q;
    logic [CH_W-1:0] sel;

    always_comb begin
        st_d = st_q;
        // the next slot leads the phase counter by one cycle
        sel = cnt + 1'b1;
        if (win_last) st_d.ready = 1'b1;
        st_d.data  = bank[sel*W_OUT +: W_OUT];
        st_d.chan  = sel;
        st_d.valid = st_q.ready;
        st_d.first = st_q.ready && (sel == '0);
        out_data  = st_q.data;
        out_chan  = st_q.chan;
        out_first = st_q.first;
        out_valid = st_q.valid;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dmx_octal_mux.sv
module dmx_octal_mux #(
    parameter int unsigned NCH  = dmx_pkg::DMX_NCH_DEF,
    parameter int unsigned W_IN = dmx_pkg::DMX_WIN_DEF,
    parameter int unsigned DEC  = dmx_pkg::DMX_DEC_DEF,
    localparam int unsigned CH_W  = $clog2(NCH),
    localparam int unsigned W_OUT = W_IN + $clog2(DEC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH*W_IN-1:0] adc_in,
    output logic [W_OUT-1:0]    out_data,
    output logic [CH_W-1:0]     out_chan,
    output logic                out_first,
    output logic                out_valid
);
    logic [CH_W-1:0]      cnt;
    logic                 cap_en, win_first, win_last;
    logic [NCH*W_OUT-1:0] bank;

    dmx_phase #(.NCH(NCH), .DEC(DEC)) u_phase (
        .clk(clk), .rst(rst), .cnt(cnt), .cap_en(cap_en),
        .win_first(win_first), .win_last(win_last)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmx_accum #(.W_IN(W_IN), .W_OUT(W_OUT)) u_acc (
            .clk(clk), .rst(rst), .cap_en(cap_en),
            .win_first(win_first), .win_last(win_last),
            .smp(adc_in[c*W_IN +: W_IN]),
            .hold(bank[c*W_OUT +: W_OUT])
        );
    end

    dmx_slot_mux #(.NCH(NCH), .W_OUT(W_OUT)) u_mux (
        .clk(clk), .rst(rst), .cnt(cnt), .win_last(win_last), .bank(bank),
        .out_data(out_data), .out_chan(out_chan),
        .out_first(out_first), .out_valid(out_valid)
    );
endmodule

// File: rtl/dmx_octal_mux_chk.sv
module dmx_octal_mux_chk #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned W_IN  = 10,
    parameter int unsigned DEC   = 4,
    parameter int unsigned CH_W  = 3,
    parameter int unsigned W_OUT = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [W_OUT-1:0] out_data,
    input logic [CH_W-1:0]  out_chan,
    input logic             out_first,
    input logic             out_valid
);
    localparam logic [W_OUT-1:0] MAX_SUM = W_OUT'(DEC * ((1 << W_IN) - 1));

    a_r3_chan_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> out_chan == CH_W'($past(out_chan) + 1'b1));

    a_r4_first_on_ch0: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_first == (out_chan == '0)));

    a_r4_first_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    a_r5_valid_holds: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    a_r5_start_ch0: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_chan == '0 && out_first));

    a_r2_sum_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data <= MAX_SUM);
endmodule

bind dmx_octal_mux dmx_octal_mux_chk #(
    .NCH(NCH), .W_IN(W_IN), .DEC(DEC), .CH_W(CH_W), .W_OUT(W_OUT)
) u_chk (
    .clk(clk), .rst(rst), .out_data(out_data), .out_chan(out_chan),
    .out_first(out_first), .out_valid(out_valid)
);

// File: tb/dmx_octal_mux_bench.sv
module dmx_octal_mux_bench;
    localparam int NCH = 8, W_IN = 10, DEC = 4, W_OUT = 12, CH_W = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NCH*W_IN-1:0] adc_in = '0;
    logic [W_OUT-1:0]    out_data;
    logic [CH_W-1:0]     out_chan;
    logic                out_first, out_valid;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmx_octal_mux u_dmx_octal_mux (
        .clk(clk), .rst(rst), .adc_in(adc_in), .out_data(out_data),
        .out_chan(out_chan), .out_first(out_first), .out_valid(out_valid)
    );

    function automatic int smp(int ch, int m, int pat);
        case (pat)
            0: return (ch * 37 + m * 113 + m * m * 7) % 1024;
            1: return 1023;
            2: return 0;
            3: return (ch == (m % NCH)) ? 1023 : 0;
            default: return (ch * 211 + m * 59 + 5) % 1024;
        endcase
    endfunction

    function automatic int junk(int ch, int j);
        return 1023 - ((ch * 71 + j * 29) % 1024);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R7: reset state
        chk("R7 valid", int'(out_valid), 0);
        chk("R7 first", int'(out_first), 0);
        chk("R7 chan", int'(out_chan), 0);
        chk("R7 data", int'(out_data), 0);
        rst = 1'b0;
    endtask

    // edges run for nedge cycles after reset release; windows below nwin are compared
    task automatic run(int nwin, int pat, int nedge);
        do_reset();
        for (int j = 0; j < nedge; j++) begin
            for (int c = 0; c < NCH; c++)
                adc_in[c*W_IN +: W_IN] = (j % 2 == 0) ? W_IN'(smp(c, j / 2, pat))
                                                       : W_IN'(junk(c, j));   // R1 odd ignored
            @(negedge clk);
            if (j < 7) begin
                chk("R5 valid low before first window", int'(out_valid), 0);
            end else begin
                int c = (j - 7) % NCH;
                int w = (j - 7) / NCH;
                if (w < nwin) begin
                    int s = 0;
                    for (int k = 0; k < DEC; k++) s += smp(c, w * DEC + k, pat);
                    chk("R5 valid", int'(out_valid), 1);
                    chk("R3 chan order", int'(out_chan), c);
                    chk("R4 first flag", int'(out_first), (c == 0) ? 1 : 0);
                    chk("R2/R6/R8/R1 sum", int'(out_data), s);
                end
            end
        end
    endtask

    initial begin
        run(6, 0, 6 * 8 + 7);
        run(3, 1, 3 * 8 + 7);    // R2 max 4092
        run(3, 2, 3 * 8 + 7);
        run(4, 3, 4 * 8 + 7);
        run(0, 4, 3);            // R7 reset mid-window next
        run(5, 4, 5 * 8 + 7);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule